// File: doc/BRIEF.md
# L1 Invalidation Walk Controller

This block serves a cache-invalidate request coming from a compute unit. Once it accepts a request, it steps through every line slot of a small L1 data cache. For each slot it reads the line address from an external tag array through an index-to-address lookup port. It then sends one eviction request downstream for that address. Evictions carry no payload and a byte count of zero.

A pending counter goes up by one for each eviction handed off and down by one for each acknowledgement that comes back. Acknowledgements may return while the walk is still going. The original request is answered with its tag only when every slot has been issued and the counter is back at zero. That answer also frees the single in-flight slot.

Only one invalidation can be outstanding. A second request seen while busy gets a retry status and is dropped, not queued. An acknowledgement that arrives while idle, or while nothing is pending, is flagged as an error and changes nothing.

Top module: `l1_inv_walker`

## Requirements
- R1: While an invalidation is in flight, `reqReady` is 0. A request presented then sees `reqRetry` = 1 in the same cycle and is discarded: it never produces evictions or a done response.
- R2: After acceptance, the block issues exactly NUM_LINES evictions. They go to indices 0, 1, …, NUM_LINES-1 in order, and each carries the address returned by the lookup port for the index on `lookupIdx`.
- R3: An eviction transfers only in a cycle where `evictValid` and `evictReady` are both 1. While it is stalled, `evictAddr` and `lookupIdx` hold steady, and the index moves on only after a transfer.
- R4: `doneValid` rises exactly when all NUM_LINES evictions have transferred and as many acknowledgements have been counted. An eviction transfer and an acknowledgement in the same cycle leave the pending count unchanged.
- R5: An `ackValid` pulse arriving while idle, or while the pending count is zero, raises `ackError` for one cycle in the following cycle. It does not change the pending count.
- R6: `doneValid` is a one-cycle pulse carrying on `doneTag` the tag captured at acceptance. In the next cycle `reqReady` is 1 again.
- R7: Every eviction reports `evictBytes` = 0.
- R8: After reset, `reqReady` = 1, and `evictValid`, `doneValid`, `reqRetry` and `ackError` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Invalidate request present |
| reqTag | input | TAG_W | Tag identifying the request |
| reqReady | output | 1 | Block idle; a presented request is accepted |
| reqRetry | output | 1 | Request refused, try again later |
| lookupIdx | output | IDX_W | Line slot being read from the tag array |
| lookupAddr | input | ADDR_W | Line address stored at `lookupIdx` |
| evictValid | output | 1 | Eviction request present |
| evictReady | input | 1 | Downstream takes the eviction |
| evictAddr | output | ADDR_W | Line address to evict |
| evictBytes | output | BYTES_W | Access size, always zero |
| ackValid | input | 1 | One eviction acknowledged |
| ackError | output | 1 | Unexpected acknowledgement seen last cycle |
| doneValid | output | 1 | Invalidation complete |
| doneTag | output | TAG_W | Tag of the completed request |

## Verification
The walk is driven with several downstream ready patterns: always ready, alternating, and sparse. These show whether the slot index advances only on a transfer and whether each eviction still carries the address for its own index. Acknowledgements come either all after the walk or one cycle behind each issue. The first pattern drives the pending count up to its full depth. The second makes an issue and an acknowledgement coincide, which separates a correct net-zero update from a lost or double count, since either fault moves the done cycle away from the one predicted. Directed cases cover a second request during a walk, acknowledgements while idle or with nothing pending, and the reset state.

// File: rtl/inv_walk_pkg.sv
package inv_walk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_DRAIN = 2'd2
  } walkState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic capture;  // request accepted, latch its tag
    logic issue;    // eviction transferred this cycle
    logic ackOk;    // acknowledgement counted
    logic ackBad;   // acknowledgement not expected
    logic finish;   // request completes this cycle
  } walkStrobe_t;

endpackage

// File: rtl/inv_walk_ctrl.sv
module inv_walk_ctrl
  import inv_walk_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              evictReady,
  input  logic              ackValid,
  input  logic              pendingZero,
  output walkStrobe_t       strobe,
  output logic [IDX_W-1:0]  walkIdx,
  output logic              busy,
  output logic              walking
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  walkState_t state, stateNext;
  logic [IDX_W-1:0] idxNext;

  assign busy    = (state != ST_IDLE);
  assign walking = (state == ST_WALK);

  always_comb begin
    strobe         = '0;
    strobe.capture = reqValid && (state == ST_IDLE);
    strobe.issue   = walking && evictReady;
    strobe.ackOk   = ackValid && busy && !pendingZero;
    strobe.ackBad  = ackValid && !strobe.ackOk;
    strobe.finish  = (state == ST_DRAIN) && pendingZero;
  end

  always_comb begin
    stateNext = state;
    idxNext   = walkIdx;
    unique case (state)
      ST_IDLE: begin
        if (strobe.capture) begin
          stateNext = ST_WALK;
          idxNext   = '0;
        end
      end
      ST_WALK: begin
        if (strobe.issue) begin
          if (walkIdx == LAST_IDX) begin
            stateNext = ST_DRAIN;
            idxNext   = '0;
          end else begin
            idxNext = walkIdx + 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (strobe.finish) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      walkIdx <= '0;
    end else begin
      state   <= stateNext;
      walkIdx <= idxNext;
    end
  end

endmodule

// File: rtl/inv_walk_dp.sv
module inv_walk_dp
  import inv_walk_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int TAG_W     = 8,
  localparam int CNT_W    = $clog2(NUM_LINES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrobe_t       strobe,
  input  logic [TAG_W-1:0]  reqTag,
  output logic [TAG_W-1:0]  heldTag,
  output logic              pendingZero,
  output logic              ackError
);

  logic [CNT_W-1:0] pendCnt;

  assign pendingZero = (pendCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendCnt <= '0;
    end else begin
      unique case ({strobe.issue, strobe.ackOk})
        2'b10:   pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;  // idle or issue+ack netting out
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heldTag <= '0;
    end else if (strobe.capture) begin
      heldTag <= reqTag;
    end else if (strobe.finish) begin
      heldTag <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ackError <= 1'b0;
    else        ackError <= strobe.ackBad;
  end

endmodule

// File: rtl/l1_inv_walker.sv
module l1_inv_walker
  import inv_walk_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 8,
  parameter int BYTES_W   = 7,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [TAG_W-1:0]   reqTag,
  output logic               reqReady,
  output logic               reqRetry,
  output logic [IDX_W-1:0]   lookupIdx,
  input  logic [ADDR_W-1:0]  lookupAddr,
  output logic               evictValid,
  input  logic               evictReady,
  output logic [ADDR_W-1:0]  evictAddr,
  output logic [BYTES_W-1:0] evictBytes,
  input  logic               ackValid,
  output logic               ackError,
  output logic               doneValid,
  output logic [TAG_W-1:0]   doneTag
);

  walkStrobe_t strobe;
  logic        busy;
  logic        walking;
  logic        pendingZero;
  logic [IDX_W-1:0] walkIdx;

  inv_walk_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .evictReady  (evictReady),
    .ackValid    (ackValid),
    .pendingZero (pendingZero),
    .strobe      (strobe),
    .walkIdx     (walkIdx),
    .busy        (busy),
    .walking     (walking)
  );

  inv_walk_dp #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .reqTag      (reqTag),
    .heldTag     (doneTag),
    .pendingZero (pendingZero),
    .ackError    (ackError)
  );

  assign reqReady   = !busy;
  assign reqRetry   = reqValid && busy;
  assign lookupIdx  = walkIdx;
  assign evictValid = walking;
  assign evictAddr  = lookupAddr;
  assign evictBytes = '0;
  assign doneValid  = strobe.finish;

endmodule

// File: rtl/inv_walk_chk.sv
module inv_walk_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqRetry,
  input logic [IDX_W-1:0]  lookupIdx,
  input logic [ADDR_W-1:0] evictAddr,
  input logic              evictValid,
  input logic              evictReady,
  input logic              ackValid,
  input logic              ackError,
  input logic              doneValid
);

  AST_RETRY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqReady) |-> reqRetry);  // R1

  AST_NO_RETRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !reqRetry);  // R1

  AST_WALK_STARTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evictValid) |-> (lookupIdx == '0));  // R2

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (evictValid && !evictReady) |=> (evictValid && $stable(lookupIdx) && $stable(evictAddr)));  // R3

  AST_IDLE_ACK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (ackValid && reqReady) |=> ackError);  // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> (!doneValid && reqReady));  // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (!evictValid && !doneValid));  // R2

endmodule

bind l1_inv_walker inv_walk_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_l1_inv_walker.sv
module test_l1_inv_walker;

  localparam int N      = 16;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 8;
  localparam int IDX_W  = $clog2(N);

  typedef struct packed {
    logic [7:0] tag;
    logic [7:0] readyMask;  // bit k: evictReady in walk cycle k mod 8
    logic       ackEager;   // 1: ack one cycle behind issue, 0: ack after walk
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{tag: 8'h11, readyMask: 8'hFF, ackEager: 1'b0},
    '{tag: 8'h2C, readyMask: 8'hFF, ackEager: 1'b1},
    '{tag: 8'h5A, readyMask: 8'h55, ackEager: 1'b1},
    '{tag: 8'hC3, readyMask: 8'h91, ackEager: 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [TAG_W-1:0] reqTag = '0;
  logic reqReady, reqRetry;
  logic [IDX_W-1:0] lookupIdx;
  logic [ADDR_W-1:0] lookupAddr;
  logic evictValid;
  logic evictReady = 1'b0;
  logic [ADDR_W-1:0] evictAddr;
  logic [6:0] evictBytes;
  logic ackValid = 1'b0;
  logic ackError, doneValid;
  logic [TAG_W-1:0] doneTag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [ADDR_W-1:0] slotAddr(input int i);
    return 32'h4000_0000 + 32'(i) * 32'h40 + ((i % 2 == 1) ? 32'h0010_0000 : 32'h0);
  endfunction

  assign lookupAddr = slotAddr(int'(lookupIdx));

  l1_inv_walker #(.NUM_LINES(N), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_l1_inv_walker (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqTag(reqTag),
    .reqReady(reqReady), .reqRetry(reqRetry), .lookupIdx(lookupIdx),
    .lookupAddr(lookupAddr), .evictValid(evictValid), .evictReady(evictReady),
    .evictAddr(evictAddr), .evictBytes(evictBytes), .ackValid(ackValid),
    .ackError(ackError), .doneValid(doneValid), .doneTag(doneTag)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic runInv(input logic [7:0] tag, input logic [7:0] mask,
                        input logic eager, input bit probeRetry, input bit badAck);
    int issued = 0;
    int outst  = 0;
    bit fin    = 0;
    bit expDone;
    check(32'(reqReady), 1, "R6 ready before request");
    reqValid = 1'b1;
    reqTag   = tag;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 0; c < 400 && !fin; c++) begin
      if (c == 1 && badAck) check(32'(ackError), 1, "R5 ack with nothing pending");
      expDone = (issued == N) && (outst == 0);
      if (doneValid !== expDone) begin
        check(32'(doneValid), 32'(expDone), "R4 done timing vs pending count");
      end
      if (doneValid) begin
        check(32'(doneTag), 32'(tag), "R6 done tag");
        check(32'(issued), N, "R2 eviction count");
        fin = 1;
      end
      ackValid   = 1'b0;
      evictReady = 1'b0;
      reqValid   = 1'b0;
      if (!fin) begin
        if (probeRetry && c == 3) begin
          reqValid = 1'b1;
          reqTag   = ~tag;
          #1;
          check(32'({reqRetry, reqReady}), 32'b10, "R1 retry while busy");
        end
        if (c == 0 && badAck) begin
          ackValid = 1'b1;
        end else begin
          evictReady = mask[c % 8];
          if (outst > 0 && (eager || issued == N)) begin
            ackValid = 1'b1;
            outst--;
          end
        end
        if (evictValid && evictReady) begin
          if (issued >= N) begin
            check(32'(issued), N - 1, "R2 too many evictions");
          end else begin
            if (evictAddr !== slotAddr(issued))
              check(evictAddr, slotAddr(issued), "R3 eviction address order");
            if (evictBytes !== 7'd0)
              check(32'(evictBytes), 0, "R7 eviction size");
          end
          issued++;
          outst++;
        end
      end
      @(negedge clk);
    end
    if (!fin) check(0, 1, "R4 done never seen");
    check(32'({reqReady, doneValid, evictValid}), 32'b100, "R6 slot free after done");
    if (probeRetry) begin
      repeat (4) begin
        @(negedge clk);
        if (doneValid || evictValid)
          check(32'({doneValid, evictValid}), 0, "R1 refused request not queued");
      end
      check(32'(reqReady), 1, "R1 still idle after refusal");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(32'({reqReady, evictValid, doneValid, reqRetry, ackError}), 32'b10000, "R8 reset outputs");

    for (int v = 0; v < NVEC; v++)
      runInv(VECS[v].tag, VECS[v].readyMask, VECS[v].ackEager, 1'b0, 1'b0);

    // R1: second request mid-walk refused and dropped
    runInv(8'h77, 8'hB7, 1'b1, 1'b1, 1'b0);

    // R5: ack with nothing pending during walk leaves the count intact
    runInv(8'h3E, 8'hFF, 1'b0, 1'b0, 1'b1);

    // R5: ack while idle
    ackValid = 1'b1;
    @(negedge clk);
    ackValid = 1'b0;
    check(32'(ackError), 1, "R5 ack while idle flagged");
    @(negedge clk);
    check(32'({ackError, doneValid, reqReady, evictValid}), 32'b0010, "R5 idle ack no effect");

    // R3: long stall keeps request steady, then a normal run
    runInv(8'h9D, 8'h01, 1'b1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule